// File: doc/BRIEF.md
# Dual-Chamber Pacing Controller

This block is the timing core of a two-chamber cardiac pacer. It watches two sense inputs, one for the upper chamber (atrium) and one for the lower chamber (ventricle). It looks after the chambers in turn. For each chamber it arms a down-counting timer and then waits for a natural beat. A beat that is sensed before the timer runs out ends that chamber's phase without a pace. If the timer runs out first, the block issues a one-cycle pace pulse to that chamber. Either way, control then passes to the other chamber.

Each timer length is a parameter counted in clock cycles. The nominal atrial escape interval is 0.8 s, which is 800 cycles at a 1 kHz tick. Simulation uses a handful of cycles. The controller has six named states:

- `ST_ARM_A`: loads the atrial timer for one cycle.
- `ST_WAIT_A`: watches for an atrial beat.
- `ST_PACE_A`: pulses the atrial pace.
- `ST_ARM_V`, `ST_WAIT_V` and `ST_PACE_V`: do the same for the ventricle.

The transitions are:

- ARM_A to WAIT_A, always.
- WAIT_A to ARM_V on an atrial sense.
- WAIT_A to PACE_A on expiry with no sense.
- PACE_A to ARM_V, always.
- The ventricular phase mirrors this, and both PACE_V and a ventricular sense lead back to ARM_A.
- Reset enters ARM_A.

Top module: `dual_chamber_pacer`

## Requirements
- R1: While `rst_n` is low, both pace outputs are 0. If no sense occurs after release, the first atrial pace is high in the cycle after A_LEN+1 rising edges, counted from the first edge after release.
- R2: When the atrial wait lasts A_LEN cycles with no atrial sense, `atr_pace` is 1 in the following cycle.
- R3: When the ventricular wait lasts V_LEN cycles with no ventricular sense, `ven_pace` is 1 in the following cycle.
- R4: An atrial sense during the atrial wait, before expiry, cancels the atrial pace, and the ventricular timer arms on the next cycle.
- R5: A ventricular sense during the ventricular wait, before expiry, cancels the ventricular pace, and the atrial timer arms on the next cycle.
- R6: A sense in the same cycle as its chamber's timer expiry counts as a beat, and no pace follows.
- R7: Each pace output is high for exactly one cycle at a time, and the two pace outputs are never high together.
- R8: A sense has no effect outside its own chamber's wait state, which covers the other chamber's phase and its own arm and pace cycles.
- R9: The chambers alternate. After an atrial pace, with no sense, the ventricular pace follows V_LEN+2 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and both timers |
| rst_n | input | 1 | Asynchronous active-low reset, enters ST_ARM_A |
| atr_sense | input | 1 | Atrial beat detected, sampled each cycle |
| ven_sense | input | 1 | Ventricular beat detected, sampled each cycle |
| atr_pace | output | 1 | One-cycle atrial pace pulse |
| ven_pace | output | 1 | One-cycle ventricular pace pulse |

## Verification
The hardest case to reach from the ports is a sense that lands exactly on the cycle in which its chamber's timer reaches zero. A sense that lands there must still win, while a sense one cycle later is already too late. The bench therefore keeps its own count of elapsed wait cycles and uses it to place each sense at a chosen offset inside the wait. It sweeps every atrial offset against every ventricular offset, including the expiry cycle and the case of no sense at all. Each combination runs twice, the second time with the sense inputs held high whenever they should be ignored.

// File: rtl/pacer_pkg.sv
package pacer_pkg;

    typedef enum logic [2:0] {
        ST_ARM_A  = 3'd0,
        ST_WAIT_A = 3'd1,
        ST_PACE_A = 3'd2,
        ST_ARM_V  = 3'd3,
        ST_WAIT_V = 3'd4,
        ST_PACE_V = 3'd5
    } pacer_state_e;

endpackage

// File: rtl/chamber_timer.sv
module chamber_timer #(
    parameter int LEN = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] START = CW'(LEN - 1);

    logic [CW-1:0] remain;

    // Load to LEN-1 during the arm cycle, then count down and hold at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= START;
        end else if (load) begin
            remain <= START;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm
    import pacer_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         atr_sense,
    input  logic         ven_sense,
    input  logic         a_zero,
    input  logic         v_zero,
    output pacer_state_e state,
    output logic         a_load,
    output logic         v_load,
    output logic         atr_pace,
    output logic         ven_pace
);
    pacer_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARM_A;
        end else begin
            state <= nxt;
        end
    end

    // A sense is tested before expiry, so a beat on the expiry cycle wins.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARM_A:  nxt = ST_WAIT_A;
            ST_WAIT_A: begin
                if (atr_sense)   nxt = ST_ARM_V;
                else if (a_zero) nxt = ST_PACE_A;
            end
            ST_PACE_A: nxt = ST_ARM_V;
            ST_ARM_V:  nxt = ST_WAIT_V;
            ST_WAIT_V: begin
                if (ven_sense)   nxt = ST_ARM_A;
                else if (v_zero) nxt = ST_PACE_V;
            end
            ST_PACE_V: nxt = ST_ARM_A;
            default:   nxt = ST_ARM_A;
        endcase
    end

    always_comb begin
        a_load   = 1'b0;
        v_load   = 1'b0;
        atr_pace = 1'b0;
        ven_pace = 1'b0;
        unique case (state)
            ST_ARM_A:  a_load   = 1'b1;
            ST_PACE_A: atr_pace = 1'b1;
            ST_ARM_V:  v_load   = 1'b1;
            ST_PACE_V: ven_pace = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_chamber_pacer.sv
module dual_chamber_pacer #(
    parameter int A_LEN = 800,
    parameter int V_LEN = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic atr_sense,
    input  logic ven_sense,
    output logic atr_pace,
    output logic ven_pace
);
    import pacer_pkg::*;

    pacer_state_e state;
    logic a_load;
    logic v_load;
    logic a_zero;
    logic v_zero;

    pacer_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .atr_sense(atr_sense),
        .ven_sense(ven_sense),
        .a_zero   (a_zero),
        .v_zero   (v_zero),
        .state    (state),
        .a_load   (a_load),
        .v_load   (v_load),
        .atr_pace (atr_pace),
        .ven_pace (ven_pace)
    );

    chamber_timer #(.LEN(A_LEN)) u_atr_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (a_load),
        .expired(a_zero)
    );

    chamber_timer #(.LEN(V_LEN)) u_ven_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (v_load),
        .expired(v_zero)
    );
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker
    import pacer_pkg::*;
#(
    parameter int A_LEN = 800,
    parameter int V_LEN = 800
) (
    input logic         clk,
    input logic         rst_n,
    input logic         atr_sense,
    input logic         ven_sense,
    input logic         atr_pace,
    input logic         ven_pace,
    input pacer_state_e state,
    input logic         a_zero,
    input logic         v_zero
);
    int a_waited;
    int v_waited;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_waited <= 0;
            v_waited <= 0;
        end else begin
            a_waited <= (state == ST_WAIT_A) ? a_waited + 1 : 0;
            v_waited <= (state == ST_WAIT_V) ? v_waited + 1 : 0;
        end
    end

    p_single_atr_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        atr_pace |=> !atr_pace);
    p_single_ven_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ven_pace |=> !ven_pace);
    p_no_dual_pace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(atr_pace && ven_pace));
    p_atr_sense_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_A && atr_sense) |=> (state == ST_ARM_V && !atr_pace));
    p_ven_sense_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_V && ven_sense) |=> (state == ST_ARM_A && !ven_pace));
    p_atr_expiry_paces_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_A && a_zero && !atr_sense) |=> atr_pace);
    p_ven_expiry_paces_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_V && v_zero && !ven_sense) |=> ven_pace);
    p_atr_wait_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_A) |-> (a_waited < A_LEN));
    p_ven_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_V) |-> (v_waited < V_LEN));
    p_after_atr_pace_r9: assert property (@(posedge clk) disable iff (!rst_n)
        atr_pace |=> (state == ST_ARM_V));
    p_after_ven_pace_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ven_pace |=> (state == ST_ARM_A));
endmodule

bind dual_chamber_pacer pacer_checker #(.A_LEN(A_LEN), .V_LEN(V_LEN)) u_pacer_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .atr_sense(atr_sense),
    .ven_sense(ven_sense),
    .atr_pace (atr_pace),
    .ven_pace (ven_pace),
    .state    (state),
    .a_zero   (a_zero),
    .v_zero   (v_zero)
);

// File: tb/test_dual_chamber_pacer.sv
module test_dual_chamber_pacer;
    localparam int A_LEN = 5;
    localparam int V_LEN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic atr_sense = 1'b0;
    logic ven_sense = 1'b0;
    logic atr_pace;
    logic ven_pace;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench view of the rhythm: phase 0 atrial / 1 ventricular,
    // sub 0 arm / 1 wait / 2 pace, wcnt cycles already waited.
    int m_phase, m_sub, m_wcnt, m_beats;
    int n_pa, n_pv, n_both, n_long, idx;
    int first_pa, first_pv;
    logic prev_pa, prev_pv;

    dual_chamber_pacer #(.A_LEN(A_LEN), .V_LEN(V_LEN)) i_dual_chamber_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .atr_sense(atr_sense),
        .ven_sense(ven_sense),
        .atr_pace (atr_pace),
        .ven_pace (ven_pace)
    );

    always #4 clk = ~clk;

    function automatic int len_of(input int ph);
        return (ph == 0) ? A_LEN : V_LEN;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        atr_sense = 1'b0;
        ven_sense = 1'b0;
        repeat (3) @(negedge clk);
        check(atr_pace == 1'b0 && ven_pace == 1'b0, "R1", "paces in reset",
              {atr_pace, ven_pace}, 0);
        rst_n = 1'b1;
        m_phase = 0; m_sub = 0; m_wcnt = 0; m_beats = 0;
        n_pa = 0; n_pv = 0; n_both = 0; n_long = 0; idx = 0;
        first_pa = -1; first_pv = -1;
        prev_pa = 1'b0; prev_pv = 1'b0;
    endtask

    // Called at a falling edge: compare, drive, advance one rising edge.
    task automatic cyc(input bit a, input bit v);
        bit exp_pa, exp_pv, sense;
        string tag;
        exp_pa = (m_phase == 0 && m_sub == 2);
        exp_pv = (m_phase == 1 && m_sub == 2);
        tag = (exp_pa || atr_pace) ? "R2" : ((exp_pv || ven_pace) ? "R3" : "R8");
        check(atr_pace == exp_pa && ven_pace == exp_pv, tag, "pace pair",
              {atr_pace, ven_pace}, {exp_pa, exp_pv});
        if (atr_pace) begin n_pa++; if (first_pa < 0) first_pa = idx; end
        if (ven_pace) begin n_pv++; if (first_pv < 0) first_pv = idx; end
        if (atr_pace && ven_pace) n_both++;
        if ((atr_pace && prev_pa) || (ven_pace && prev_pv)) n_long++;
        prev_pa = atr_pace;
        prev_pv = ven_pace;
        atr_sense = a;
        ven_sense = v;
        @(posedge clk);
        sense = (m_phase == 0) ? a : v;
        case (m_sub)
            0: begin m_sub = 1; m_wcnt = 0; end
            1: begin
                if (sense) begin
                    if (m_phase == 1) m_beats++;
                    m_phase = 1 - m_phase;
                    m_sub = 0;
                end else if (m_wcnt == len_of(m_phase) - 1) begin
                    m_sub = 2;
                end else begin
                    m_wcnt++;
                end
            end
            default: begin
                if (m_phase == 1) m_beats++;
                m_phase = 1 - m_phase;
                m_sub = 0;
            end
        endcase
        idx++;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", idx, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int noise = 0; noise < 2; noise++) begin
            for (int ka = 0; ka <= A_LEN; ka++) begin
                for (int kv = 0; kv <= V_LEN; kv++) begin
                    int exp_pa, exp_pv;
                    string ta, tv;
                    do_reset();
                    while (m_beats < 3 && idx < 400) begin
                        bit in_aw, in_vw, a, v;
                        in_aw = (m_phase == 0 && m_sub == 1);
                        in_vw = (m_phase == 1 && m_sub == 1);
                        a = (in_aw && m_wcnt == ka) || (noise == 1 && !in_aw);
                        v = (in_vw && m_wcnt == kv) || (noise == 1 && !in_vw);
                        cyc(a, v);
                    end
                    exp_pa = (ka == A_LEN) ? 3 : 0;
                    exp_pv = (kv == V_LEN) ? 3 : 0;
                    ta = (ka == A_LEN) ? "R2" : ((ka == A_LEN - 1) ? "R6" : "R4");
                    tv = (kv == V_LEN) ? "R3" : ((kv == V_LEN - 1) ? "R6" : "R5");
                    if (noise == 1) begin ta = "R8"; tv = "R8"; end
                    check(n_pa == exp_pa, ta, "atrial pace count", n_pa, exp_pa);
                    check(n_pv == exp_pv, tv, "ventricular pace count", n_pv, exp_pv);
                    check(n_both == 0 && n_long == 0, "R7", "overlap or wide pulse",
                          n_both + n_long, 0);
                    if (ka == A_LEN) begin
                        check(first_pa == A_LEN + 1, "R1", "first atrial pace cycle",
                              first_pa, A_LEN + 1);
                        if (kv == V_LEN)
                            check(first_pv - first_pa == V_LEN + 2, "R9",
                                  "atrial-to-ventricular pace gap",
                                  first_pv - first_pa, V_LEN + 2);
                    end
                end
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule